// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block sits at the end of a floating-point operation. It takes the five raw IEEE exception flags the operation raised, the current value of the floating-point status register and the current program-counter pair. From these it works out whether the operation must trap. In one clock cycle it produces the rewritten status register and the next program-counter pair.

The register is updated on a single valid strobe. On a trap, the block reduces the enabled flags that were raised to one flag, chosen by a fixed priority. It marks the trap type and leaves both program counters where they were. Without a trap, the raw flags go into the current-exception field, they are also merged into the accrued field, and execution steps past the instruction. A one-cycle trap request accompanies the registered result.

Top module: `fpx_status_recorder`

## Requirements
- R1: Status layout: trap-enable mask at bits 27:23, accrued field at bits 9:5, current field at bits 4:0, trap-type field at bits 16:14. Within each five-bit field the flag bits are invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R2: One cycle after a strobe, `trap_req` is 1 exactly when the raw flags and the trap-enable mask of `status_in` share a set bit. In every other cycle it is 0.
- R3: On a trap, the current field holds exactly one flag: the highest-priority raised flag that is also enabled. The priority order is invalid, overflow, underflow, divide-by-zero, inexact.
- R4: Without a trap, the current field is replaced by the raw flags, including the all-zero case. The old value is never merged in.
- R5: Without a trap, the accrued field becomes its old value ORed with the raw flags. On a trap, it keeps its old value.
- R6: On a trap, the trap-type field is written with code 1. Without a trap, it keeps its old value.
- R7: Without a trap, `pc_out` takes `npc_in` and `npc_out` takes `npc_in` plus 4, wrapping modulo 2^PC_W.
- R8: On a trap, `pc_out` takes `pc_in` and `npc_out` takes `npc_in`.
- R9: Every status bit outside the current, accrued and trap-type fields is copied unchanged from `status_in`.
- R10: A synchronous reset clears all outputs. While the strobe is low, `status_out`, `pc_out` and `npc_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: an operation has completed this cycle |
| op_flags | input | 5 | Raw exception flags of the operation |
| status_in | input | STAT_W (64) | Current status register value |
| pc_in | input | PC_W (64) | Current program counter |
| npc_in | input | PC_W (64) | Current next program counter |
| status_out | output | STAT_W (64) | Registered rewritten status register |
| pc_out | output | PC_W (64) | Registered program counter |
| npc_out | output | PC_W (64) | Registered next program counter |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The trap decision and the priority reduction happen in the same cycle, and both depend on the same mask. When several enabled flags are raised together, the bench must see a single-bit current field and a held PC pair. When only disabled flags are raised, it must see the full flag set, an accrual and a PC advance. The bench sweeps every combination of the 32 flag patterns and the 32 mask patterns. For each combination it compares the status field, the PC pair and the trap request against a model that uses if-else priority. Separate cases cover wrap-around of the next PC, holding while the strobe is low, and reset.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_N  = 5;
  localparam int CUR_LSB = 0;
  localparam int ACC_LSB = 5;
  localparam int TT_LSB  = 14;
  localparam int TT_W    = 3;
  localparam int TEM_LSB = 23;
  localparam int TOP_BIT = TEM_LSB + FLAG_N - 1;
  localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

  typedef logic [FLAG_N-1:0] fpx_flags_t;

  // The priority order matches the bit order, so the highest set bit wins.
  function automatic fpx_flags_t fpx_keep_top(input fpx_flags_t f);
    fpx_flags_t r;
    r = '0;
    for (int i = 0; i < FLAG_N; i++)
      if (f[i]) r = fpx_flags_t'(1) << i;
    return r;
  endfunction

  function automatic logic fpx_would_trap(input fpx_flags_t raw, input fpx_flags_t tem);
    return |(raw & tem);
  endfunction
endpackage

// File: rtl/fpx_trap_judge.sv
module fpx_trap_judge
  import fpx_pkg::*;
(
  input  fpx_flags_t raw_flags,
  input  fpx_flags_t tem_mask,
  output logic       trap,
  output fpx_flags_t res_flags
);
  fpx_flags_t enabled_hit;

  always_comb begin
    enabled_hit = raw_flags & tem_mask;
    trap        = fpx_would_trap(raw_flags, tem_mask);
    res_flags   = trap ? fpx_keep_top(enabled_hit) : raw_flags;
  end
endmodule

// File: rtl/fpx_field_merge.sv
module fpx_field_merge
  import fpx_pkg::*;
#(
  parameter int STAT_W = 64
) (
  input  logic [STAT_W-1:0] stat_cur,
  input  fpx_flags_t        res_flags,
  input  logic              trap,
  output logic [STAT_W-1:0] stat_nxt
);
  always_comb begin
    stat_nxt = stat_cur;
    stat_nxt[CUR_LSB +: FLAG_N] = res_flags;
    if (trap)
      stat_nxt[TT_LSB +: TT_W] = TT_IEEE;
    else
      stat_nxt[ACC_LSB +: FLAG_N] = stat_cur[ACC_LSB +: FLAG_N] | res_flags;
  end
endmodule

// File: rtl/fpx_pc_adv.sv
module fpx_pc_adv #(
  parameter int PC_W    = 64,
  parameter int PC_STEP = 4
) (
  input  logic [PC_W-1:0] pc_cur,
  input  logic [PC_W-1:0] npc_cur,
  input  logic            trap,
  output logic [PC_W-1:0] pc_nxt,
  output logic [PC_W-1:0] npc_nxt
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_comb begin
    if (trap) begin
      pc_nxt  = pc_cur;
      npc_nxt = npc_cur;
    end else begin
      pc_nxt  = npc_cur;
      npc_nxt = npc_cur + STEP;
    end
  end
endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder
  import fpx_pkg::*;
#(
  parameter int STAT_W  = 64,
  parameter int PC_W    = 64,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [4:0]        op_flags,
  input  logic [STAT_W-1:0] status_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [PC_W-1:0]   npc_in,
  output logic [STAT_W-1:0] status_out,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   npc_out,
  output logic              trap_req
);
  // The status register must be wide enough to hold the trap-enable mask.
  initial assert (STAT_W > TOP_BIT);

  fpx_flags_t        tem_w;
  fpx_flags_t        res_w;
  logic              trap_w;
  logic [STAT_W-1:0] stat_nxt_w;
  logic [PC_W-1:0]   pc_nxt_w;
  logic [PC_W-1:0]   npc_nxt_w;

  assign tem_w = status_in[TEM_LSB +: FLAG_N];

  fpx_trap_judge u_judge (
    .raw_flags (op_flags),
    .tem_mask  (tem_w),
    .trap      (trap_w),
    .res_flags (res_w)
  );

  fpx_field_merge #(.STAT_W(STAT_W)) u_merge (
    .stat_cur  (status_in),
    .res_flags (res_w),
    .trap      (trap_w),
    .stat_nxt  (stat_nxt_w)
  );

  fpx_pc_adv #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
    .pc_cur  (pc_in),
    .npc_cur (npc_in),
    .trap    (trap_w),
    .pc_nxt  (pc_nxt_w),
    .npc_nxt (npc_nxt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_out <= '0;
      pc_out     <= '0;
      npc_out    <= '0;
      trap_req   <= 1'b0;
    end else begin
      trap_req <= op_valid & trap_w;
      if (op_valid) begin
        status_out <= stat_nxt_w;
        pc_out     <= pc_nxt_w;
        npc_out    <= npc_nxt_w;
      end
    end
  end

  // R2: the trap request follows from the mask and the flags seen at the strobe.
  assert_trap_match_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> trap_req == $past(|(op_flags & status_in[TEM_LSB +: FLAG_N])));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !trap_req);
  assert_single_flag_R3: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $countones(status_out[CUR_LSB +: FLAG_N]) == 1);
  assert_accr_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && trap_w) |=> status_out[ACC_LSB +: FLAG_N] == $past(status_in[ACC_LSB +: FLAG_N]));
  assert_ttype_set_R6: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> status_out[TT_LSB +: TT_W] == TT_IEEE);
  assert_pc_held_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && trap_w) |=> (pc_out == $past(pc_in)) && (npc_out == $past(npc_in)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(status_out) && $stable(pc_out) && $stable(npc_out));
endmodule

// File: tb/test_fpx_status_recorder.sv
`timescale 1ns/1ps
module test_fpx_status_recorder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_flags = '0;
  logic [63:0] status_in = '0;
  logic [63:0] pc_in = '0;
  logic [63:0] npc_in = '0;
  logic [63:0] status_out, pc_out, npc_out;
  logic        trap_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  fpx_status_recorder i_fpx_status_recorder (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
    .status_in(status_in), .pc_in(pc_in), .npc_in(npc_in),
    .status_out(status_out), .pc_out(pc_out), .npc_out(npc_out),
    .trap_req(trap_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent priority: invalid, overflow, underflow, divide-by-zero, inexact.
  function automatic logic [4:0] pick(input logic [4:0] e);
    if (e[4]) return 5'b10000;
    else if (e[3]) return 5'b01000;
    else if (e[2]) return 5'b00100;
    else if (e[1]) return 5'b00010;
    else if (e[0]) return 5'b00001;
    return 5'b00000;
  endfunction

  task automatic run_op(input logic [4:0] fl, input logic [4:0] mask,
                        input logic [63:0] base, input logic [63:0] pc, input logic [63:0] npc);
    logic [63:0] sin, exp_s, exp_pc, exp_npc;
    logic        tr;
    logic [4:0]  res;
    sin = base;
    sin[27:23] = mask;
    tr  = (fl & mask) != 5'd0;
    res = tr ? pick(fl & mask) : fl;
    exp_s = sin;
    exp_s[4:0] = res;
    if (tr) exp_s[16:14] = 3'd1;
    else    exp_s[9:5]   = sin[9:5] | fl;
    exp_pc  = tr ? pc  : npc;
    exp_npc = tr ? npc : npc + 64'd4;
    @(negedge clk);
    op_valid = 1'b1; op_flags = fl; status_in = sin; pc_in = pc; npc_in = npc;
    @(negedge clk);
    op_valid = 1'b0;
    chk(trap_req == tr, "R2 trap", {63'd0, trap_req}, {63'd0, tr});
    if (tr) chk(status_out[4:0] == res, "R3 single flag", status_out, exp_s);
    else    chk(status_out[4:0] == res, "R4 current replaced", status_out, exp_s);
    chk(status_out[9:5] == exp_s[9:5], "R5 accrued", status_out, exp_s);
    chk(status_out[16:14] == exp_s[16:14], "R6 trap type", status_out, exp_s);
    chk(status_out == exp_s, "R9 R1 full status", status_out, exp_s);
    if (tr) begin
      chk(pc_out == exp_pc && npc_out == exp_npc, "R8 pc held", pc_out, exp_pc);
    end else begin
      chk(pc_out == exp_pc && npc_out == exp_npc, "R7 pc advance", npc_out, exp_npc);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(status_out == 64'd0 && pc_out == 64'd0 && npc_out == 64'd0 && !trap_req,
        "R10 reset", status_out, 64'd0);
    rst = 1'b0;

    for (int m = 0; m < 32; m++) begin
      for (int f = 0; f < 32; f++) begin
        logic [63:0] base;
        base = 64'hA5C3_5A3C_0F96_E1B7 ^ {32'(m * 977), 32'(f * 40503)};
        run_op(5'(f), 5'(m), base, 64'h4000 + 64'(m * 256 + f * 8), 64'h4004 + 64'(m * 256 + f * 8));
      end
    end

    // R7 wrap of the next PC, no flags (R4 zero case)
    run_op(5'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFC);
    // R3 all flags enabled and raised, invalid wins
    run_op(5'h1F, 5'h1F, 64'd0, 64'h100, 64'h104);
    // R3 only lower-priority flags enabled
    run_op(5'h1F, 5'b00011, 64'd0, 64'h200, 64'h204);

    // R10 hold while strobe low, inputs changing
    begin
      logic [63:0] s0, p0, n0;
      s0 = status_out; p0 = pc_out; n0 = npc_out;
      op_flags = 5'h1F; status_in = 64'hFFFF_FFFF_FFFF_FFFF; pc_in = 64'h1; npc_in = 64'h2;
      repeat (3) @(negedge clk);
      chk(status_out == s0 && pc_out == p0 && npc_out == n0, "R10 hold", status_out, s0);
      chk(!trap_req, "R2 idle no trap", {63'd0, trap_req}, 64'd0);
    end

    // R10 synchronous reset after activity
    rst = 1'b1;
    @(negedge clk);
    chk(status_out == 64'd0 && pc_out == 64'd0 && npc_out == 64'd0, "R10 reset again", status_out, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule